// File: doc/BRIEF.md
# Complementary Three-Phase PWM Generator

This block drives a three-phase inverter bridge. It produces three high-side/low-side gate pairs from a symmetric triangular carrier, so every pulse is centred on the carrier crest. The carrier comes from two 16-bit counters that step in lockstep. The lagging counter traces the triangle. The leading counter runs ahead of it by the dead-time value, so the low-side edges sit exactly one dead time away from the high-side edges on both slopes. One period value and one dead-time value are shared by all phases, and each phase has its own compare value. All of them are written into shadow storage and reach the active copy only at a carrier turning point.

A vector of event inputs, filtered by a mask, acts as the shut-off request. An overcurrent comparator routed through an event network is one such source. A masked event blanks all six gates in the same cycle and drops the pad enable, which puts the pins into high impedance. It also sets a latched fault flag, and the outputs stay released until that flag is cleared. When counting starts, a one-cycle start pulse is issued so that a helper timer can place converter triggers inside the PWM cycle.

Top module: `cpwm3_top`

## Requirements
- R1: After reset all gate outputs are 0, the pad enable `drv_en` is 1, `fault` is 0 and `start_evt` is 0.
- R2: While running, the lagging counter steps by one per clock: 0, 1, … P, P-1, … 1, 0, 1 …. This gives a carrier period of 2·P clocks. The leading counter always equals lagging + D. A high-side pulse with compare M lasts 2·(P−M)+1 clocks and is centred on the crest.
- R3: One clock after a carrier state, the high side of a phase is active when lagging ≥ M, and the low side is active when lagging + D < M. Both sides are off for exactly D clocks at each transition, and the two outputs of a pair are never active together.
- R4: A high-side pulse is suppressed when M + D > P. A low-side pulse never appears when M ≤ D.
- R5: `cfg_wr` captures the period, dead time and the three compares (phase k in bits [16k+15:16k]) into shadow storage. New compares become active at a crest or a trough. Period and dead time become active only at a trough. While idle, or in the first running cycle, all shadow values are adopted at once.
- R6: When `run` rises, the carrier restarts at 0 counting upward, and `start_evt` is high for exactly one clock, in the first counting cycle.
- R7: One clock after `run` is low, all six gate outputs are 0.
- R8: In the same cycle that any event bit with its mask bit set to 1 is high, `drv_en` is 0 and all six gate outputs are 0.
- R9: A masked event sets `fault` on the next clock. `fault` holds, and keeps `drv_en` at 0, until `fault_clr` is high in a cycle with no masked event. A masked event wins over the clear.
- R10: Event bits whose mask bit is 0 have no effect on `drv_en`, the gates or `fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run | input | 1 | Carrier enable; a rising edge restarts the carrier |
| cfg_wr | input | 1 | Write strobe for the shadow settings |
| cfg_period | input | 16 | Carrier crest value P |
| cfg_dead | input | 16 | Dead time D in clocks |
| cfg_cmp | input | 48 | Phase compares M, phase k in bits [16k+15:16k] |
| trip_evt | input | 8 | Linked shut-off event requests |
| trip_mask | input | 8 | 1 = the matching event bit may shut off the outputs |
| fault_clr | input | 1 | Clears the latched fault |
| gate_hi | output | 3 | High-side gate drives, one per phase |
| gate_lo | output | 3 | Low-side gate drives, one per phase |
| drv_en | output | 1 | Pad enable: 1 drives the gates, 0 leaves them high impedance |
| fault | output | 1 | Latched shut-off status |
| start_evt | output | 1 | One-clock pulse when counting begins |

## Verification
The assertions take for granted that the period is at least 1 and that period plus dead time fits in 16 bits. Without these limits the leading counter would wrap and the carrier-range and offset properties would not hold. They also assume that no shut-off event arrives during the two clocks in which the internal reset is still being released. The random stimulus draws periods from 4 to 40 and dead times from 0 to 5, and it holds the event inputs at zero until reset has settled. Compares are drawn from 0 to P+3, so the suppression paths on both sides of a pair are exercised often.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  typedef enum logic {
    SLOPE_UP = 1'b0,
    SLOPE_DN = 1'b1
  } slope_e;

  localparam int RST_STAGES = 2;
endpackage

// File: rtl/cpwm_rst_sync.sv
module cpwm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/cpwm_carrier.sv
module cpwm_carrier
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cfg_wr,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic [CNT_W-1:0] cfg_dead,
  output logic [CNT_W-1:0] lag_o,
  output logic [CNT_W-1:0] lead_o,
  output logic [CNT_W-1:0] per_o,
  output logic [CNT_W-1:0] dead_o,
  output logic             active_o,
  output logic             cmp_ld_o,
  output logic             start_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             run_q, run_d;
  slope_e           slope_q, slope_d;
  logic [CNT_W-1:0] lag_q, lag_d;
  logic [CNT_W-1:0] lead_q, lead_d;
  logic [CNT_W-1:0] per_q, per_d;
  logic [CNT_W-1:0] dead_q, dead_d;
  logic [CNT_W-1:0] per_sh_q, dead_sh_q;
  logic             start_q, start_d;
  logic             at_crest, at_trough, active;

  assign active    = run & run_q;
  assign at_crest  = (slope_q == SLOPE_UP) && (lag_q >= per_q);
  assign at_trough = (slope_q == SLOPE_DN) && (lag_q == '0);

  // next-state: two counters stepping together, lead offset by dead time
  always_comb begin
    run_d   = run;
    start_d = run & ~run_q;
    slope_d = slope_q;
    lag_d   = lag_q;
    lead_d  = lead_q;
    per_d   = per_q;
    dead_d  = dead_q;
    if (!run) begin
      per_d  = per_sh_q;
      dead_d = dead_sh_q;
    end else if (!run_q) begin
      slope_d = SLOPE_UP;
      lag_d   = '0;
      lead_d  = dead_sh_q;
      per_d   = per_sh_q;
      dead_d  = dead_sh_q;
    end else if (at_crest) begin
      slope_d = SLOPE_DN;
      lag_d   = lag_q - ONE;
      lead_d  = lead_q - ONE;
    end else if (at_trough) begin
      slope_d = SLOPE_UP;
      lag_d   = ONE;
      lead_d  = dead_sh_q + ONE;
      per_d   = per_sh_q;
      dead_d  = dead_sh_q;
    end else if (slope_q == SLOPE_UP) begin
      lag_d   = lag_q + ONE;
      lead_d  = lead_q + ONE;
    end else begin
      lag_d   = lag_q - ONE;
      lead_d  = lead_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      start_q <= 1'b0;
      slope_q <= SLOPE_UP;
      lag_q   <= '0;
      lead_q  <= '0;
      per_q   <= '0;
      dead_q  <= '0;
    end else begin
      run_q   <= run_d;
      start_q <= start_d;
      slope_q <= slope_d;
      lag_q   <= lag_d;
      lead_q  <= lead_d;
      per_q   <= per_d;
      dead_q  <= dead_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_sh_q  <= '0;
      dead_sh_q <= '0;
    end else if (cfg_wr) begin
      per_sh_q  <= cfg_period;
      dead_sh_q <= cfg_dead;
    end
  end

  assign lag_o    = lag_q;
  assign lead_o   = lead_q;
  assign per_o    = per_q;
  assign dead_o   = dead_q;
  assign active_o = active;
  assign cmp_ld_o = ~active | at_crest | at_trough;
  assign start_o  = start_q;
endmodule

// File: rtl/cpwm_phase.sv
module cpwm_phase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CNT_W-1:0] cfg_cmp,
  input  logic             cmp_ld,
  input  logic             active,
  input  logic [CNT_W-1:0] lag,
  input  logic [CNT_W-1:0] lead,
  input  logic [CNT_W-1:0] per,
  input  logic [CNT_W-1:0] dead,
  output logic             hi_o,
  output logic             lo_o
);
  logic [CNT_W-1:0] cmp_sh_q, cmp_q;
  logic             hi_q, hi_d, lo_q, lo_d;
  logic             room;

  // the high pulse must leave at least one dead time before the crest
  assign room = ({1'b0, cmp_q} + {1'b0, dead}) <= {1'b0, per};

  always_comb begin
    hi_d = active & (lag >= cmp_q) & room;
    lo_d = active & (lead < cmp_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_sh_q <= '0;
    else if (cfg_wr) cmp_sh_q <= cfg_cmp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_q <= '0;
    else if (cmp_ld) cmp_q <= cmp_sh_q;
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;
endmodule

// File: rtl/cpwm_trip.sv
module cpwm_trip #(
  parameter int N_EVT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt,
  input  logic [N_EVT-1:0] mask,
  input  logic             clr,
  output logic             hit_o,
  output logic             fault_o,
  output logic             drv_en_o
);
  logic fault_q, fault_d;
  logic hit;

  assign hit = |(evt & mask);

  always_comb begin
    fault_d = fault_q;
    if (hit)      fault_d = 1'b1;
    else if (clr) fault_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= fault_d;
  end

  assign hit_o    = hit;
  assign fault_o  = fault_q;
  assign drv_en_o = ~(fault_q | hit);
endmodule

// File: rtl/cpwm3_top.sv
module cpwm3_top
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int N_PH  = 3,
  parameter int N_EVT = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  input  logic                  cfg_wr,
  input  logic [CNT_W-1:0]      cfg_period,
  input  logic [CNT_W-1:0]      cfg_dead,
  input  logic [N_PH*CNT_W-1:0] cfg_cmp,
  input  logic [N_EVT-1:0]      trip_evt,
  input  logic [N_EVT-1:0]      trip_mask,
  input  logic                  fault_clr,
  output logic [N_PH-1:0]       gate_hi,
  output logic [N_PH-1:0]       gate_lo,
  output logic                  drv_en,
  output logic                  fault,
  output logic                  start_evt
);
  logic             rst_sync_n;
  logic [CNT_W-1:0] car_lag, car_lead, car_per, car_dead;
  logic             car_active, car_cmp_ld;
  logic             trip_hit;
  logic [N_PH-1:0]  hi_raw, lo_raw;

  cpwm_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cpwm_carrier #(.CNT_W(CNT_W)) u_car (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .run        (run),
    .cfg_wr     (cfg_wr),
    .cfg_period (cfg_period),
    .cfg_dead   (cfg_dead),
    .lag_o      (car_lag),
    .lead_o     (car_lead),
    .per_o      (car_per),
    .dead_o     (car_dead),
    .active_o   (car_active),
    .cmp_ld_o   (car_cmp_ld),
    .start_o    (start_evt)
  );

  for (genvar k = 0; k < N_PH; k++) begin : g_ph
    cpwm_phase #(.CNT_W(CNT_W)) u_ph (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .cfg_wr  (cfg_wr),
      .cfg_cmp (cfg_cmp[k*CNT_W +: CNT_W]),
      .cmp_ld  (car_cmp_ld),
      .active  (car_active),
      .lag     (car_lag),
      .lead    (car_lead),
      .per     (car_per),
      .dead    (car_dead),
      .hi_o    (hi_raw[k]),
      .lo_o    (lo_raw[k])
    );
  end

  cpwm_trip #(.N_EVT(N_EVT)) u_trip (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .evt      (trip_evt),
    .mask     (trip_mask),
    .clr      (fault_clr),
    .hit_o    (trip_hit),
    .fault_o  (fault),
    .drv_en_o (drv_en)
  );

  assign gate_hi = hi_raw & {N_PH{drv_en}};
  assign gate_lo = lo_raw & {N_PH{drv_en}};
endmodule

// File: rtl/cpwm3_chk.sv
module cpwm3_chk #(
  parameter int CNT_W = 16,
  parameter int N_PH  = 3
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             run,
  input logic             fault_clr,
  input logic [N_PH-1:0]  gate_hi,
  input logic [N_PH-1:0]  gate_lo,
  input logic             drv_en,
  input logic             fault,
  input logic             start_evt,
  input logic             trip_hit,
  input logic             car_active,
  input logic [CNT_W-1:0] car_lag,
  input logic [CNT_W-1:0] car_lead,
  input logic [CNT_W-1:0] car_per,
  input logic [CNT_W-1:0] car_dead
);
  // R3
  no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (gate_hi & gate_lo) == '0);

  // R2
  carrier_range_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    car_active |-> (car_lag <= car_per));

  // R2
  lead_offset_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    car_active |-> (car_lead == car_lag + car_dead));

  // R6
  start_once_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start_evt |=> !start_evt);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !run |=> (gate_hi == '0 && gate_lo == '0));

  // R8
  trip_blank_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    trip_hit |-> (!drv_en && gate_hi == '0 && gate_lo == '0));

  // R9
  fault_set_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    trip_hit |=> fault);

  // R9
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fault && !fault_clr) |=> fault);

  // R10
  mask_ignore_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!trip_hit && !fault) |-> drv_en);
endmodule

bind cpwm3_top cpwm3_chk #(.CNT_W(CNT_W), .N_PH(N_PH)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .run        (run),
  .fault_clr  (fault_clr),
  .gate_hi    (gate_hi),
  .gate_lo    (gate_lo),
  .drv_en     (drv_en),
  .fault      (fault),
  .start_evt  (start_evt),
  .trip_hit   (trip_hit),
  .car_active (car_active),
  .car_lag    (car_lag),
  .car_lead   (car_lead),
  .car_per    (car_per),
  .car_dead   (car_dead)
);

// File: tb/cpwm3_top_tb.sv
`timescale 1ns/1ps
module cpwm3_top_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        run, cfg_wr, fault_clr;
  logic [15:0] cfg_period, cfg_dead;
  logic [47:0] cfg_cmp;
  logic [7:0]  trip_evt, trip_mask;
  logic [2:0]  gate_hi, gate_lo;
  logic        drv_en, fault, start_evt;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit chk_on  = 1'b0;

  always #5 clk = ~clk;

  cpwm3_top u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_wr(cfg_wr),
    .cfg_period(cfg_period), .cfg_dead(cfg_dead), .cfg_cmp(cfg_cmp),
    .trip_evt(trip_evt), .trip_mask(trip_mask), .fault_clr(fault_clr),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .drv_en(drv_en),
    .fault(fault), .start_evt(start_evt)
  );

  // reference model written from the requirements
  int   m_lag, m_per, m_dead, m_psh, m_dsh;
  int   m_csh [3];
  int   m_cact[3];
  bit   m_up, m_runq, m_fault, m_start;
  logic [2:0] m_hi, m_lo;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lag <= 0; m_per <= 0; m_dead <= 0; m_psh <= 0; m_dsh <= 0;
      for (int k = 0; k < 3; k++) begin m_csh[k] <= 0; m_cact[k] <= 0; end
      m_up <= 1'b1; m_runq <= 1'b0; m_fault <= 1'b0; m_start <= 1'b0;
      m_hi <= '0; m_lo <= '0;
    end else begin
      bit act;
      act = run && m_runq;
      if (|(trip_evt & trip_mask)) m_fault <= 1'b1;
      else if (fault_clr)          m_fault <= 1'b0;
      if (cfg_wr) begin
        m_psh <= int'(cfg_period);
        m_dsh <= int'(cfg_dead);
        for (int k = 0; k < 3; k++) m_csh[k] <= int'(cfg_cmp[16*k +: 16]);
      end
      m_start <= run && !m_runq;
      m_runq  <= run;
      for (int k = 0; k < 3; k++) begin
        m_hi[k] <= act && (m_lag >= m_cact[k]) && (m_cact[k] + m_dead <= m_per);
        m_lo[k] <= act && (m_lag + m_dead < m_cact[k]);
      end
      if (!run) begin
        m_per <= m_psh; m_dead <= m_dsh;
        for (int k = 0; k < 3; k++) m_cact[k] <= m_csh[k];
      end else if (!m_runq) begin
        m_lag <= 0; m_up <= 1'b1; m_per <= m_psh; m_dead <= m_dsh;
        for (int k = 0; k < 3; k++) m_cact[k] <= m_csh[k];
      end else if (m_up && m_lag >= m_per) begin
        m_up <= 1'b0; m_lag <= m_lag - 1;
        for (int k = 0; k < 3; k++) m_cact[k] <= m_csh[k];
      end else if (!m_up && m_lag == 0) begin
        m_up <= 1'b1; m_lag <= 1; m_per <= m_psh; m_dead <= m_dsh;
        for (int k = 0; k < 3; k++) m_cact[k] <= m_csh[k];
      end else begin
        m_lag <= m_up ? m_lag + 1 : m_lag - 1;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model, away from the edges
  always @(posedge clk) begin
    #2;
    if (chk_on) begin
      bit en;
      en = !(m_fault || (|(trip_evt & trip_mask)));
      check("R3 R4 R5 gate_hi", 32'(gate_hi), 32'(m_hi & {3{en}}));
      check("R3 R4 R5 gate_lo", 32'(gate_lo), 32'(m_lo & {3{en}}));
      check("R8 R10 drv_en", 32'(drv_en), 32'(en));
      check("R9 fault", 32'(fault), 32'(m_fault));
      check("R6 start_evt", 32'(start_evt), 32'(m_start));
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #3;
  endtask

  task automatic set_cfg(input int p, input int d, input int a, input int b, input int c);
    cfg_period = 16'(p); cfg_dead = 16'(d);
    cfg_cmp = {16'(c), 16'(b), 16'(a)};
    cfg_wr = 1'b1; step(); cfg_wr = 1'b0;
  endtask

  initial begin
    int cnt, seen;
    void'($urandom(32'd2718));
    rst_n = 1'b0; run = 1'b0; cfg_wr = 1'b0; fault_clr = 1'b0;
    cfg_period = '0; cfg_dead = '0; cfg_cmp = '0;
    trip_evt = '0; trip_mask = '0;
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    chk_on = 1'b1;
    repeat (3) step();

    // R1: reset state
    check("R1 gate_hi", 32'(gate_hi), 0);
    check("R1 gate_lo", 32'(gate_lo), 0);
    check("R1 drv_en", 32'(drv_en), 1);
    check("R1 fault", 32'(fault), 0);
    check("R1 start_evt", 32'(start_evt), 0);

    // P=20, D=3, phase a M=8, phase b M=15, phase c M=2
    set_cfg(20, 3, 8, 15, 2);
    trip_mask = 8'h04;
    run = 1'b1;
    step();
    check("R6 start pulse high", 32'(start_evt), 1);
    step();
    check("R6 start pulse single", 32'(start_evt), 0);

    // R3: dead gap between low-side fall and high-side rise
    cnt = 0; while (gate_lo[0] !== 1'b1 && cnt < 200) begin step(); cnt++; end
    cnt = 0; while (gate_lo[0] !== 1'b0 && cnt < 200) begin step(); cnt++; end
    cnt = 0; while (gate_hi[0] !== 1'b1 && cnt < 200) begin
      if (gate_lo[0] === 1'b0) cnt++;
      step();
    end
    check("R3 dead gap cycles", 32'(cnt), 3);
    // R2: high width 2*(20-8)+1 and period 2*20
    cnt = 0; while (gate_hi[0] === 1'b1 && cnt < 200) begin step(); cnt++; end
    check("R2 high pulse width", 32'(cnt), 25);
    seen = cnt;
    while (gate_hi[0] !== 1'b1 && cnt < 400) begin step(); cnt++; end
    check("R2 carrier period", 32'(cnt), 40);
    // R4: phase c (M=2 <= D=3) never drives its low side
    seen = 0;
    for (int i = 0; i < 80; i++) begin
      if (gate_lo[2] === 1'b1) seen++;
      step();
    end
    check("R4 low side suppressed", 32'(seen), 0);

    // R4: phase a with M=18, 18+3 > 20, high side suppressed
    set_cfg(20, 3, 18, 15, 2);
    repeat (45) step();
    seen = 0; cnt = 0;
    for (int i = 0; i < 80; i++) begin
      if (gate_hi[0] === 1'b1) seen++;
      if (gate_lo[0] === 1'b1) cnt++;
      step();
    end
    check("R4 high side suppressed", 32'(seen), 0);
    check("R4 low side still active", 32'(cnt > 0), 1);

    // R10: unmasked bit ignored
    trip_evt = 8'h01; #1;
    check("R10 drv_en with masked-off bit", 32'(drv_en), 1);
    step(); trip_evt = '0;
    check("R10 fault not set", 32'(fault), 0);
    // R8: enabled bit blanks immediately
    while (gate_hi[1] !== 1'b1) step();
    trip_evt = 8'h04; #1;
    check("R8 drv_en low same cycle", 32'(drv_en), 0);
    check("R8 gates blanked", 32'({gate_hi, gate_lo}), 0);
    step(); trip_evt = '0; #1;
    check("R9 fault latched", 32'(fault), 1);
    repeat (10) step();
    check("R9 fault holds", 32'({fault, drv_en}), 32'h2);
    trip_evt = 8'h04; fault_clr = 1'b1; step();
    trip_evt = '0;
    check("R9 event wins over clear", 32'(fault), 1);
    step(); fault_clr = 1'b0; #1;
    check("R9 cleared", 32'({fault, drv_en}), 32'h1);

    // R7: run low silences the gates
    run = 1'b0; step();
    seen = 0;
    for (int i = 0; i < 30; i++) begin
      if ({gate_hi, gate_lo} !== 6'b0) seen++;
      step();
    end
    check("R7 idle gates", 32'(seen), 0);

    // constrained random phase; model comparison names R2 R3 R4 R5
    trip_mask = 8'($urandom_range(1, 255));
    run = 1'b1;
    for (int i = 0; i < 6000; i++) begin
      int r, p;
      r = $urandom_range(0, 999);
      cfg_wr = 1'b0;
      if (r < 25) begin
        p = $urandom_range(4, 40);
        cfg_period = 16'(p);
        cfg_dead = 16'($urandom_range(0, 5));
        cfg_cmp = {16'($urandom_range(0, p + 3)), 16'($urandom_range(0, p + 3)),
                   16'($urandom_range(0, p + 3))};
        cfg_wr = 1'b1;
      end
      trip_evt = (r >= 25 && r < 33) ? 8'($urandom) : 8'h00;
      fault_clr = (r >= 100 && r < 200);
      if (r >= 996) run = ~run;
      step();
    end
    cfg_wr = 1'b0; trip_evt = '0; fault_clr = 1'b0;
    step(); step();
    summary();
    $finish;
  end
endmodule